// File: doc/BRIEF.md
# SPI Master Word Sequencer

This block is the transfer engine on the master side of a serial peripheral link. Words wait in a small transmit queue. The engine takes them one at a time, shifts each out most significant bit first on the serial clock and data-out lines, and assembles the bits it samples on the data-in line into a receive word. An external prescaler supplies a one-cycle tick once per half period of the serial clock. Every serial clock edge lands on one of these ticks, and all delays in the engine are counted in them.

The configuration inputs set the following:
- the word length, as an encoded value;
- the number of idle serial clock cycles between words that follow each other;
- the clock polarity and phase;
- when a word counts as finished.

An optional automatic select mode replaces the normal select value with an alternate value while a transfer is running. It can add a lead-in delay before the first clock edge. It can also drop the alternate value during each inter-word gap. A transfer-in-progress flag tells software when the last queued word has completed.

Top module: `spi_word_seq`

## Requirements
- R1: The 4-bit length code `len_code` selects the word size N. Code 0 gives N=32 bits. Codes 3 to 15 give N = code+1 bits. The illegal codes 1 and 2 give N=4 bits. Each word produces exactly N serial clock cycles. Bits [N-1:0] of the queued word are sent, bit N-1 first, and higher bits are ignored.
- R2: While no word is shifting, `sck` rests at `cpol`. With `cpha`=0 the data-out bit is valid before the first edge of each bit, and `miso` is sampled on the leading edge. With `cpha`=1 the data-out bit changes on the leading edge and `miso` is sampled on the trailing edge.
- R3: After the last bit of a word is sampled, `rx_valid` pulses for one cycle. `rx_data[N-1:0]` then holds the sampled bits, the first sampled bit in position N-1, and the bits above N-1 are zero.
- R4: If the queue is not empty when a word ends, the first edge of the next word comes 2*G+1 ticks after the last edge of the previous word, where G is `gap_cycles`. G=0 therefore gives back-to-back words.
- R5: Once the queue has drained, the engine goes idle. A newly written word starts at the next tick, whatever the value of G.
- R6: With `auto_sel`=1, `ss_n` changes from `ss_normal` to `ss_alt` when a transfer starts. It returns to `ss_normal` when the final queued word completes. With `auto_sel`=0, `ss_n` always equals `ss_normal`.
- R7: After a switch to `ss_alt`, the first serial clock edge falls on tick D+1, where D is `sel_delay`. D therefore sets the lead-in delay in half periods.
- R8: With `gap_toggle`=1 and `auto_sel`=1, `ss_n` returns to `ss_normal` at the start of each gap. It switches back to `ss_alt` at the end of the gap, and the R7 delay applies again. G must be at least 2 in this mode.
- R9: `tip` rises when a transfer starts and falls when the final queued word completes. With `cpha`=0 and `end_on_idle`=0, a word completes on its last sampling edge, while `sck` is still active. Otherwise a word completes once `sck` is back at its idle level.
- R10: The queue holds 4 words and `q_full` is high while it holds 4. A write while `q_full` is high is dropped.
- R11: `sck` changes only on cycles that follow a cycle with `tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Half-period pulse from the prescaler |
| len_code | input | 4 | Encoded word length |
| gap_cycles | input | 5 | Serial clock cycles inserted between queued words |
| auto_sel | input | 1 | Enables automatic select switching |
| sel_delay | input | 2 | Lead-in delay, in half periods |
| gap_toggle | input | 1 | Drops the alternate select during each gap |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Sampling phase |
| end_on_idle | input | 1 | Completion waits for the clock to return to idle |
| ss_normal | input | 4 | Select value outside transfers |
| ss_alt | input | 4 | Select value during transfers |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 32 | Word to queue |
| q_full | output | 1 | Queue full |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Select lines |
| rx_data | output | 32 | Last received word |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` updates |
| tip | output | 1 | Transfer in progress |

## Verification
The assertions assume that the configuration inputs stay constant while the engine is busy. They also assume that G is at least 2 whenever gap toggling is on, and that `tick` never rises more than once in a single cycle. The stimulus holds to all of this. It changes configuration only after `tip` has fallen and several half periods of silence have passed, and it gives the tick a fixed period of four cycles. With that fixed period, every expected distance between edges is an exact multiple of four cycles.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int WORD_W = 32;
  localparam int NB_W   = $clog2(WORD_W) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_GAP} eng_st_t;

  // Decoded word size from the 4-bit length code.
  function automatic logic [NB_W-1:0] word_bits(input logic [3:0] code);
    if (code == 4'd0)      return NB_W'(WORD_W);
    else if (code < 4'd3)  return NB_W'(4);
    else                   return NB_W'(code) + NB_W'(1);
  endfunction
endpackage

// File: rtl/spi_txq.sv
module spi_txq #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          accept;

  assign accept = push && !full;
  assign empty  = (cnt == '0);
  assign full   = (cnt == (AW+1)'(DEPTH));
  assign dout   = mem[rp];

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (accept) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (pop)    rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      cnt <= cnt + (AW+1)'(accept) - (AW+1)'(pop);
    end
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R10
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng
  import spi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [3:0]        cfg_len,
  input  logic [4:0]        cfg_gap,
  input  logic              cfg_asel,
  input  logic [1:0]        cfg_adel,
  input  logic              cfg_tog,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_cite,
  input  logic              q_empty,
  input  logic [WORD_W-1:0] q_data,
  output logic              q_pop,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              sel,
  output logic              tip,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int EW = NB_W + 1;

  eng_st_t           st;
  logic              ph, fin_r, tip_r, sel_r, mosi_r, rx_v;
  logic [EW-1:0]     ec, cnt;
  logic [NB_W-1:0]   nbits;
  logic [WORD_W-1:0] tx_sh, rx_sh, rx_data_r;

  // Named events for the checks below.
  logic              shifting, do_shift, do_sample, last_smp, last_edge, comp_ev;
  logic              going_idle, load, lead_sw;
  logic [EW-1:0]     k, two_n, comp_k, smp_last;
  logic [NB_W-1:0]   nb_new, sh_amt;
  logic [WORD_W-1:0] aligned;

  assign shifting   = tick && (st == ST_SHIFT);
  assign k          = ec + EW'(1);
  assign two_n      = {nbits, 1'b0};
  assign comp_k     = (!cfg_cpha && !cfg_cite) ? two_n - EW'(1) : two_n;
  assign smp_last   = cfg_cpha ? two_n : two_n - EW'(1);
  assign do_sample  = shifting && (cfg_cpha ? !k[0] : k[0]);
  assign do_shift   = shifting && (cfg_cpha ? k[0] : (!k[0] && k != two_n));
  assign last_smp   = do_sample && (k == smp_last);
  assign last_edge  = shifting && (k == two_n);
  assign comp_ev    = shifting && (k == comp_k) && !fin_r;
  assign going_idle = last_edge && (fin_r || q_empty);
  assign load       = ((st == ST_IDLE) && !q_empty)
                   || (last_edge && !going_idle && cfg_gap == 5'd0)
                   || ((st == ST_GAP) && tick && cnt == EW'(1));
  assign lead_sw    = cfg_asel && ((st == ST_IDLE) || ((st == ST_GAP) && cfg_tog));
  assign nb_new     = word_bits(cfg_len);
  assign sh_amt     = NB_W'(WORD_W) - nb_new;
  assign aligned    = q_data << sh_amt;

  assign q_pop    = load;
  assign sck      = cfg_cpol ^ ph;
  assign mosi     = mosi_r;
  assign sel      = sel_r;
  assign tip      = tip_r;
  assign rx_data  = rx_data_r;
  assign rx_valid = rx_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ph        <= 1'b0;
      fin_r     <= 1'b0;
      tip_r     <= 1'b0;
      sel_r     <= 1'b0;
      mosi_r    <= 1'b0;
      rx_v      <= 1'b0;
      ec        <= '0;
      cnt       <= '0;
      nbits     <= NB_W'(4);
      tx_sh     <= '0;
      rx_sh     <= '0;
      rx_data_r <= '0;
    end else begin
      rx_v <= 1'b0;
      case (st)
        ST_LEAD: if (tick) begin
          cnt <= cnt - EW'(1);
          if (cnt == EW'(1)) st <= ST_SHIFT;
        end
        ST_GAP: if (tick) cnt <= cnt - EW'(1);
        ST_SHIFT: if (tick) begin
          ph <= ~ph;
          ec <= k;
          if (do_shift) begin
            mosi_r <= tx_sh[WORD_W-1];
            tx_sh  <= tx_sh << 1;
          end
          if (do_sample) begin
            rx_sh <= {rx_sh[WORD_W-2:0], miso};
            if (last_smp) begin
              rx_data_r <= {rx_sh[WORD_W-2:0], miso};
              rx_v      <= 1'b1;
            end
          end
          if (comp_ev && q_empty) begin
            fin_r <= 1'b1;
            tip_r <= 1'b0;
            sel_r <= 1'b0;
          end
          if (last_edge) begin
            if (going_idle) st <= ST_IDLE;
            else if (cfg_gap != 5'd0) begin
              st  <= ST_GAP;
              cnt <= {1'b0, cfg_gap, 1'b0};
              if (cfg_asel && cfg_tog) sel_r <= 1'b0;
            end
          end
        end
        default: ;
      endcase
      if (load) begin
        nbits <= nb_new;
        ec    <= '0;
        fin_r <= 1'b0;
        tip_r <= 1'b1;
        rx_sh <= '0;
        if (!cfg_cpha) begin
          mosi_r <= aligned[WORD_W-1];
          tx_sh  <= aligned << 1;
        end else begin
          tx_sh  <= aligned;
        end
        if (lead_sw) begin
          sel_r <= 1'b1;
          if (cfg_adel != 2'd0) begin
            st  <= ST_LEAD;
            cnt <= EW'(cfg_adel);
          end else st <= ST_SHIFT;
        end else st <= ST_SHIFT;
      end
    end
  end

  AST_SCK_REST:    assert property (@(posedge clk) disable iff (!rst_n) (st != ST_SHIFT) |-> (ph == 1'b0)); // R2
  AST_TICK_PACE:   assert property (@(posedge clk) disable iff (!rst_n) !$stable(ph) |-> $past(tick)); // R11
  AST_RXV_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) rx_v |=> !rx_v); // R3
  AST_IDLE_NOSEL:  assert property (@(posedge clk) disable iff (!rst_n) (st == ST_IDLE) |-> !sel_r); // R6
  AST_IDLE_NOTIP:  assert property (@(posedge clk) disable iff (!rst_n) (st == ST_IDLE) |-> !tip_r); // R9
  AST_GAP_DESEL:   assert property (@(posedge clk) disable iff (!rst_n)
                     ((st == ST_GAP) && cfg_tog && cfg_asel) |-> !sel_r); // R8
  AST_LEAD_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) (st == ST_LEAD) |-> (sel_r && $stable(ph))); // R7
endmodule

// File: rtl/spi_word_seq.sv
module spi_word_seq
  import spi_seq_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int SSW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [3:0]        len_code,
  input  logic [4:0]        gap_cycles,
  input  logic              auto_sel,
  input  logic [1:0]        sel_delay,
  input  logic              gap_toggle,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              end_on_idle,
  input  logic [SSW-1:0]    ss_normal,
  input  logic [SSW-1:0]    ss_alt,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              q_full,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [SSW-1:0]    ss_n,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              tip
);
  logic              q_empty, q_pop, sel;
  logic [WORD_W-1:0] q_data;

  spi_txq #(.W(WORD_W), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .din(wr_data),
    .pop(q_pop), .dout(q_data), .empty(q_empty), .full(q_full)
  );

  spi_shift_eng u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_len(len_code), .cfg_gap(gap_cycles), .cfg_asel(auto_sel),
    .cfg_adel(sel_delay), .cfg_tog(gap_toggle), .cfg_cpol(cpol),
    .cfg_cpha(cpha), .cfg_cite(end_on_idle),
    .q_empty(q_empty), .q_data(q_data), .q_pop(q_pop),
    .miso(miso), .sck(sck), .mosi(mosi), .sel(sel), .tip(tip),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  for (genvar i = 0; i < SSW; i++) begin : g_ss
    assign ss_n[i] = sel ? ss_alt[i] : ss_normal[i];
  end

  AST_SEL_NEEDS_TIP: assert property (@(posedge clk) disable iff (!rst_n) (!auto_sel) |-> (ss_n == ss_normal)); // R6
endmodule

// File: tb/sim_spi_word_seq.sv
module sim_spi_word_seq;
  localparam int P     = 4;
  localparam int LIMIT = 150000;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [3:0]  len_code = 4'd7;
  logic [4:0]  gap_cycles = 5'd0;
  logic        auto_sel = 1'b0, gap_toggle = 1'b0, cpol = 1'b0, cpha = 1'b0, end_on_idle = 1'b0;
  logic [1:0]  sel_delay = 2'd0;
  logic [3:0]  ss_normal = 4'b1111, ss_alt = 4'b1110;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        q_full, sck, mosi, miso, rx_valid, tip;
  logic [3:0]  ss_n;
  logic [31:0] rx_data;

  assign miso = mosi;  // loopback

  spi_word_seq u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .len_code(len_code), .gap_cycles(gap_cycles),
    .auto_sel(auto_sel), .sel_delay(sel_delay), .gap_toggle(gap_toggle), .cpol(cpol),
    .cpha(cpha), .end_on_idle(end_on_idle), .ss_normal(ss_normal), .ss_alt(ss_alt),
    .wr_en(wr_en), .wr_data(wr_data), .q_full(q_full), .sck(sck), .mosi(mosi),
    .miso(miso), .ss_n(ss_n), .rx_data(rx_data), .rx_valid(rx_valid), .tip(tip)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int e_n, lead_n, ss_chg, ss_t0, rx_n;
  int edge_t [256];
  logic [31:0] rx_w [16];
  logic [31:0] tx_w [8];
  logic sck_q, tip_q, tip_seen, tipfall_sck;
  logic [3:0] ss_q;

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Tick generator and output monitor, both away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      tick = (cyc % P == 0);
      if (sck !== sck_q) begin
        if (e_n < 256) edge_t[e_n] = cyc;
        e_n++;
        if (sck != cpol) lead_n++;
      end
      sck_q = sck;
      if (ss_n !== ss_q) begin
        ss_chg++;
        if (ss_chg == 1) ss_t0 = cyc;
      end
      ss_q = ss_n;
      if (rx_valid) begin
        if (rx_n < 16) rx_w[rx_n] = rx_data;
        rx_n++;
      end
      if (tip && !tip_q) tip_seen = 1'b1;
      if (!tip && tip_q) tipfall_sck = sck;
      tip_q = tip;
      if (cyc > LIMIT) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
        finish_up();
      end
    end
  end

  function automatic int exp_bits(input int c);
    if (c >= 3) return c + 1;
    return (c == 0) ? 32 : 4;
  endfunction

  function automatic logic [31:0] low_mask(input logic [31:0] d, input int n);
    if (n >= 32) return d;
    return d & ((32'd1 << n) - 32'd1);
  endfunction

  task automatic clr_mon();
    e_n = 0; lead_n = 0; ss_chg = 0; ss_t0 = 0; rx_n = 0; tip_seen = 1'b0;
    sck_q = sck; ss_q = ss_n; tip_q = tip; tipfall_sck = sck;
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wr_en = 1'b1; wr_data = tx_w[i];
    end
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (tip) @(negedge clk);
    repeat (4 * P) @(negedge clk);
  endtask

  initial begin
    int nb, d, w;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state: R2 idle clock, R6 normal select, R9 tip low, R10 queue empty
    chk(sck == cpol, "R2 reset sck", sck, cpol);
    chk(ss_n == ss_normal, "R6 reset ss_n", ss_n, ss_normal);
    chk(!tip && !rx_valid, "R9 reset tip", tip, 0);
    chk(!q_full, "R10 reset q_full", q_full, 0);

    // R1 R2 R3: every length code under every polarity/phase, two back-to-back words
    for (int code = 0; code < 16; code++) begin
      for (int m = 0; m < 4; m++) begin
        len_code = 4'(code); cpol = m[0]; cpha = m[1];
        gap_cycles = 5'd0; auto_sel = 1'b0;
        nb = exp_bits(code);
        tx_w[0] = 32'hC3A5_5A3C ^ (32'(code) * 32'h0101_0111) ^ (32'(m) << 9);
        tx_w[1] = {tx_w[0][18:0], tx_w[0][31:19]} ^ 32'h9E37_79B9;
        @(negedge clk); clr_mon();
        push_n(2);
        wait_idle();
        chk(lead_n == 2 * nb, "R1 sck cycles", lead_n, 2 * nb);
        chk(rx_n == 2, "R3 rx pulses", rx_n, 2);
        chk(rx_w[0] == low_mask(tx_w[0], nb), "R3 word0", rx_w[0], low_mask(tx_w[0], nb));
        chk(rx_w[1] == low_mask(tx_w[1], nb), "R2 word1 phase", rx_w[1], low_mask(tx_w[1], nb));
        chk(sck == cpol, "R2 idle level", sck, cpol);
        chk(ss_chg == 0, "R6 no swap when disabled", ss_chg, 0);
      end
    end

    // R4 R11: gap spacing between the last edge of word 0 and first edge of word 1
    len_code = 4'd7; cpol = 1'b0; cpha = 1'b0;
    foreach (tx_w[i]) tx_w[i] = 32'h5A + 32'(i * 37);
    for (int g = 0; g < 6; g++) begin
      gap_cycles = 5'(g);
      @(negedge clk); clr_mon();
      push_n(2);
      wait_idle();
      d = edge_t[16] - edge_t[15];
      chk(d == (2 * g + 1) * P, "R4 gap spacing", d, (2 * g + 1) * P);
      chk(edge_t[1] - edge_t[0] == P, "R11 edge pacing", edge_t[1] - edge_t[0], P);
    end

    // R5: idle engine restarts at the next tick despite a long gap setting
    gap_cycles = 5'd31;
    @(negedge clk); clr_mon();
    push_n(1);
    wait_idle();
    @(negedge clk); clr_mon(); w = cyc + 1;
    push_n(1);
    wait_idle();
    d = edge_t[0] - w;
    chk(d >= 1 && d <= P + 3, "R5 restart latency", d, P + 3);

    // R6 R7: automatic select and lead-in delay
    gap_cycles = 5'd0; auto_sel = 1'b1;
    for (int dl = 0; dl < 4; dl++) begin
      sel_delay = 2'(dl);
      @(negedge clk); clr_mon();
      push_n(1);
      wait_idle();
      d = edge_t[0] - ss_t0;
      chk(d >= dl * P + 1 && d <= (dl + 1) * P, "R7 lead delay", d, (dl + 1) * P);
      chk(ss_chg == 2, "R6 swap and restore", ss_chg, 2);
      chk(ss_n == ss_normal, "R6 restored", ss_n, ss_normal);
    end

    // R8: select toggles at both ends of the gap
    sel_delay = 2'd0; gap_cycles = 5'd2; gap_toggle = 1'b1;
    @(negedge clk); clr_mon();
    push_n(2);
    wait_idle();
    chk(ss_chg == 4, "R8 toggle count", ss_chg, 4);
    chk(rx_n == 2, "R8 words delivered", rx_n, 2);
    gap_toggle = 1'b0;
    @(negedge clk); clr_mon();
    push_n(2);
    wait_idle();
    chk(ss_chg == 2, "R8 no toggle when off", ss_chg, 2);
    auto_sel = 1'b0; gap_cycles = 5'd0;

    // R9: completion point versus phase and end mode
    for (int mode = 0; mode < 3; mode++) begin
      cpha = (mode == 2); end_on_idle = (mode == 1);
      @(negedge clk); clr_mon();
      push_n(1);
      wait_idle();
      chk(tip_seen, "R9 tip raised", tip_seen, 1);
      if (mode == 0) chk(tipfall_sck == !cpol, "R9 early completion", tipfall_sck, !cpol);
      else           chk(tipfall_sck == cpol, "R9 idle completion", tipfall_sck, cpol);
    end
    cpha = 1'b0; end_on_idle = 1'b0;

    // R10: queue fills at four waiting words, sixth write dropped
    len_code = 4'd0;
    foreach (tx_w[i]) tx_w[i] = 32'h1234_0000 + 32'(i * 4097);
    @(negedge clk); clr_mon();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); wr_en = 1'b1; wr_data = tx_w[i];
    end
    @(negedge clk); wr_en = 1'b0;
    chk(q_full, "R10 full flag", q_full, 1);
    wait_idle();
    chk(rx_n == 5, "R10 dropped write", rx_n, 5);
    for (int i = 0; i < 5; i++)
      chk(rx_w[i] == tx_w[i], "R10 order", rx_w[i], tx_w[i]);
    chk(!q_full, "R10 drained", q_full, 0);

    finish_up();
  end
endmodule